// File: doc/BRIEF.md
# Four-Channel Timestamp Capture Unit

The block records when external events happen. Four input pins are watched, each for a chosen kind of transition. When a channel sees its transition, the unit copies the value of a shared 32-bit free-running counter into that channel's capture register and raises that channel's status flag. The counter itself is outside the block and arrives on an input port.

The last channel has a second trigger source. When an enable bit is set, a one-cycle compare-match pulse from another counter/compare pair also makes that channel latch the counter value. Software reads the captured times and the flags over a small register bus. Capture registers accept full 32-bit reads only. A flag is cleared with a read-then-write-zero sequence. A standby input wipes all captured state.

Top module: `icap_quad`

## Requirements
- R1: After reset, all capture registers, all status flags and the control register read as zero.
- R2: Channel n's edge select is control bits [2n+1:2n], and the control register is at address 4. The encodings are 00 = no capture, 01 = rising edges only, 10 = falling edges only, 11 = both edges. A transition that is not selected causes no capture and no flag.
- R3: A selected pin transition set up before rising clock edge E1 is latched on the third rising edge E3, using the counter value present at E3. This follows from two synchroniser stages and one edge-history stage.
- R4: A capture sets that channel's flag on the same clock edge that loads the register. Flags are status bits [3:0] at address 5.
- R5: A flag read as 1 from the status register is cleared by a later status write with a 0 in that bit. Any status write disarms every flag. A 0 written without a prior read of 1 has no effect, and a 1 written has no effect.
- R6: When a capture and an armed clear hit the same flag on the same edge, the flag ends up set.
- R7: Control bit 8 enables the alternate trigger. While it is 1, a compare-match pulse present at a clock edge makes channel 3 latch that edge's counter value and set its flag. While it is 0, the pulse is ignored.
- R8: A channel-3 pin event and a compare-match pulse on the same edge produce one capture of that edge's counter value.
- R9: A 32-bit read of address n (0..3) returns capture register n. A 16-bit read of a capture register returns zero, raises the error output for one cycle, and changes no state.
- R10: While standby is high, capture registers and flags are held at zero and no capture is taken. The control register is kept.
- R11: Writes to addresses 0..3 are ignored. Capture registers are read-only.
- R12: Read data and the error output are registered. They appear on the clock edge after the edge that samples the request. The control register reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| standby | input | 1 | Standby: clears and holds capture state |
| cap_pin | input | 4 | Asynchronous capture inputs, one per channel |
| cnt_val | input | 32 | Shared free-running counter value |
| cmp_match | input | 1 | Compare-match pulse, alternate trigger for channel 3 |
| bus_en | input | 1 | Bus request valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_long | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse on a 16-bit read of a capture register |

## Verification
Each channel is given a different edge mode, and its pin is driven through both transitions. A capture on exactly the selected transitions separates the four encodings from one another. The bench drives a counter that changes every cycle, so the latched value shows the exact capture edge and exposes any extra or missing pipeline stage. Some stimuli are placed on a chosen edge: a pin edge coinciding with an armed clear, a pin edge coinciding with a compare-match pulse, and compare-match pulses with the enable off and then on. Together these tell apart set priority, single capture and gating of the alternate trigger. Word reads, writes to read-only addresses and standby are each followed by a read of the state they must or must not disturb.

// File: rtl/icap_pkg.sv
package icap_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  // Edge decision from the current and previous synchronised samples.
  function automatic logic edge_hit(edge_sel_e sel, logic cur, logic prev);
    logic hit;
    unique case (sel)
      EDGE_RISE: hit = cur & ~prev;
      EDGE_FALL: hit = ~cur & prev;
      EDGE_BOTH: hit = cur ^ prev;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/icap_edge_det.sv
module icap_edge_det
  import icap_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin,
  input  edge_sel_e sel,
  output logic      evt
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign cur = sync_q[STAGES-1];
  assign evt = edge_hit(sel, cur, prev_q);

  // R2: a disabled channel never reports an event
  p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == EDGE_OFF) |-> !evt);

  // R2: a rising-only channel reports only when the synchronised level is high
  p_rise_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == EDGE_RISE && evt) |-> cur);

endmodule

// File: rtl/icap_channel.sv
module icap_channel #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          standby,
  input  logic          fire,
  input  logic          flag_clr,
  input  logic [CW-1:0] cnt_val,
  output logic [CW-1:0] cap_q,
  output logic          flag_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else if (standby) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (fire) cap_q <= cnt_val;
      if (fire)          flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  // R3: a capture holds the counter value of its own edge
  p_latch_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !standby) |=> (cap_q == $past(cnt_val)));

  // R4 / R6: a capture always leaves the flag set, even against a clear
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !standby) |=> flag_q);

  // R5: without a clear or standby the flag cannot drop
  p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr && !standby) |=> flag_q);

  // R11: the register only changes through a capture or standby
  p_ro_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !standby) |=> $stable(cap_q));

  // R10: standby empties the channel
  p_standby_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (cap_q == '0 && !flag_q));

endmodule

// File: rtl/icap_regbus.sv
module icap_regbus #(
  parameter int NCH = 4,
  parameter int CW  = 32,
  parameter int AW  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     standby,
  input  logic                     bus_en,
  input  logic                     bus_wr,
  input  logic                     bus_long,
  input  logic [AW-1:0]            bus_addr,
  input  logic [CW-1:0]            bus_wdata,
  input  logic [NCH-1:0][CW-1:0]   cap_all,
  input  logic [NCH-1:0]           flag_all,
  output logic [2*NCH:0]           ctrl_q,
  output logic [NCH-1:0]           flag_clr,
  output logic [CW-1:0]            bus_rdata,
  output logic                     bus_err
);

  localparam int CTRLW = 2*NCH + 1;
  localparam int IW    = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NCH);
  localparam logic [AW-1:0] STAT_ADDR = AW'(NCH + 1);

  logic [NCH-1:0] arm_q;
  logic           rd_req, wr_req, is_cap, cap_word_rd;
  logic           wdata_unused;

  assign rd_req      = bus_en && !bus_wr;
  assign wr_req      = bus_en && bus_wr;
  assign is_cap      = bus_addr < AW'(NCH);
  assign cap_word_rd = rd_req && is_cap && !bus_long;
  assign wdata_unused = ^bus_wdata[CW-1:CTRLW];

  // A flag may drop only if it was armed by a read that returned 1
  always_comb begin
    for (int i = 0; i < NCH; i++)
      flag_clr[i] = wr_req && (bus_addr == STAT_ADDR) && arm_q[i] && !bus_wdata[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      arm_q  <= '0;
    end else begin
      if (wr_req && bus_addr == CTRL_ADDR) ctrl_q <= bus_wdata[CTRLW-1:0];
      if (standby)                                   arm_q <= '0;
      else if (wr_req && bus_addr == STAT_ADDR)      arm_q <= '0;
      else if (rd_req && bus_addr == STAT_ADDR)      arm_q <= flag_all;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err <= cap_word_rd;
      if (rd_req) begin
        if (is_cap)                      bus_rdata <= bus_long ? cap_all[bus_addr[IW-1:0]] : '0;
        else if (bus_addr == CTRL_ADDR)  bus_rdata <= CW'(ctrl_q);
        else if (bus_addr == STAT_ADDR)  bus_rdata <= CW'(flag_all);
        else                             bus_rdata <= '0;
      end
    end
  end

  // R9: an error response never carries data
  p_err_zero_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0));

  // R12: the control register changes only through a bus write
  p_ctrl_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |=> $stable(ctrl_q));

endmodule

// File: rtl/icap_quad.sv
module icap_quad
  import icap_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CW     = 32,
  parameter int AW     = 3,
  parameter int STAGES = 2,
  parameter int ALT_CH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           standby,
  input  logic [NCH-1:0] cap_pin,
  input  logic [CW-1:0]  cnt_val,
  input  logic           cmp_match,
  input  logic           bus_en,
  input  logic           bus_wr,
  input  logic           bus_long,
  input  logic [AW-1:0]  bus_addr,
  input  logic [CW-1:0]  bus_wdata,
  output logic [CW-1:0]  bus_rdata,
  output logic           bus_err
);

  localparam int CTRLW = 2*NCH + 1;

  logic [CTRLW-1:0]         ctrl_q;
  logic                     trg_en;
  logic [NCH-1:0]           evt;
  logic [NCH-1:0]           fire;
  logic [NCH-1:0]           flag_clr;
  logic [NCH-1:0]           flag_all;
  logic [NCH-1:0][CW-1:0]   cap_all;

  assign trg_en = ctrl_q[2*NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    icap_edge_det #(.STAGES(STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (cap_pin[i]),
      .sel   (edge_sel_e'(ctrl_q[2*i +: 2])),
      .evt   (evt[i])
    );

    if (i == ALT_CH) begin : g_alt
      // Both sources merge into one strobe: coincident triggers latch once
      assign fire[i] = evt[i] | (trg_en & cmp_match);
    end else begin : g_pin
      assign fire[i] = evt[i];
    end

    icap_channel #(.CW(CW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .standby  (standby),
      .fire     (fire[i]),
      .flag_clr (flag_clr[i]),
      .cnt_val  (cnt_val),
      .cap_q    (cap_all[i]),
      .flag_q   (flag_all[i])
    );
  end

  icap_regbus #(.NCH(NCH), .CW(CW), .AW(AW)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby   (standby),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_long  (bus_long),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cap_all   (cap_all),
    .flag_all  (flag_all),
    .ctrl_q    (ctrl_q),
    .flag_clr  (flag_clr),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err)
  );

  // R7: an enabled compare-match pulse captures that edge's counter value
  p_alt_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trg_en && cmp_match && !standby) |=>
      (flag_all[ALT_CH] && cap_all[ALT_CH] == $past(cnt_val)));

  // R8: merging sources never yields more than the channel count of strobes
  p_fire_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fire) <= $countones(evt) + 1);

endmodule

// File: tb/icap_quad_tb.sv
module icap_quad_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0;
  logic [3:0]  cap_pin = '0;
  logic [31:0] cnt_val = 32'h00FF_FF00;
  logic        cmp_match = 1'b0;
  logic        bus_en = 1'b0, bus_wr = 1'b0, bus_long = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  logic rd_seen = 1'b0;

  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cnt_val <= cnt_val + 32'd1;
    rd_seen <= bus_en && !bus_wr;
  end

  icap_quad u_dut (
    .clk(clk), .rst_n(rst_n), .standby(standby), .cap_pin(cap_pin),
    .cnt_val(cnt_val), .cmp_match(cmp_match), .bus_en(bus_en),
    .bus_wr(bus_wr), .bus_long(bus_long), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  // Monitor: pops one expected response per read, one cycle after the request
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [32:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      vectors++;
      if ({bus_err, bus_rdata} !== e) begin
        fails++;
        $display("FAIL %s: got err=%b data=%h expected err=%b data=%h",
                 t, bus_err, bus_rdata, e[32], e[31:0]);
      end
    end
  end

  task automatic rd(input logic [2:0] a, input bit lng, input logic [31:0] ed,
                    input bit ee, input string t);
    @(negedge clk);
    bus_en = 1; bus_wr = 0; bus_addr = a; bus_long = lng;
    exp_q.push_back({ee, ed});
    tag_q.push_back(t);
    @(negedge clk);
    bus_en = 0; bus_long = 1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_long = 1;
    @(negedge clk);
    bus_en = 0; bus_wr = 0;
  endtask

  task automatic pin(input int ch, input bit v, output logic [31:0] c);
    @(negedge clk);
    cap_pin[ch] = v;
    c = cnt_val;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] c0, c1, c2, c3, cx;
    idle(3);
    rst_n = 1;
    idle(2);

    // R1 reset state
    for (int a = 0; a < 6; a++) rd(3'(a), 1, 32'h0, 0, "R1 reset value");

    // R2 / R12 program modes: ch0 rise, ch1 fall, ch2 both, ch3 off
    wr(3'd4, 32'h39);
    rd(3'd4, 1, 32'h39, 0, "R12 control readback");

    // R3 / R4 rising capture on channel 0
    pin(0, 1, c0); idle(5);
    rd(3'd0, 1, c0 + 32'd2, 0, "R3 ch0 rise value");
    rd(3'd5, 1, 32'h1, 0, "R4 ch0 flag");

    // R2 falling-only channel ignores a rise, takes a fall
    pin(1, 1, cx); idle(5);
    rd(3'd5, 1, 32'h1, 0, "R2 ch1 rise ignored");
    pin(1, 0, c1); idle(5);
    rd(3'd1, 1, c1 + 32'd2, 0, "R2 ch1 fall value");

    // R2 both edges on channel 2
    pin(2, 1, c2); idle(5);
    rd(3'd2, 1, c2 + 32'd2, 0, "R2 ch2 rise value");
    pin(2, 0, c2); idle(5);
    rd(3'd2, 1, c2 + 32'd2, 0, "R2 ch2 fall value");

    // R2 disabled channel 3
    pin(3, 1, cx); idle(5);
    pin(3, 0, cx); idle(5);
    rd(3'd3, 1, 32'h0, 0, "R2 ch3 off no capture");
    rd(3'd5, 1, 32'h7, 0, "R2 flags after modes");

    // R9 word read of a capture register
    rd(3'd0, 0, 32'h0, 1, "R9 word read error");
    rd(3'd0, 1, c0 + 32'd2, 0, "R9 state kept after word read");

    // R11 write to capture register ignored
    wr(3'd0, 32'hDEAD_BEEF);
    rd(3'd0, 1, c0 + 32'd2, 0, "R11 write ignored");

    // R5 clear protocol
    rd(3'd5, 1, 32'h7, 0, "R5 arm read");
    wr(3'd5, 32'hFFFF_FFFE);
    wr(3'd5, 32'h0);
    rd(3'd5, 1, 32'h6, 0, "R5 armed clear and unarmed write");

    // R6 set wins over a clear on the same edge
    pin(0, 0, cx); idle(5);
    pin(0, 1, cx); idle(5);
    pin(0, 0, cx); idle(5);
    rd(3'd5, 1, 32'h7, 0, "R6 arm all");
    pin(0, 1, c0);
    @(negedge clk);
    wr(3'd5, 32'h0);
    idle(3);
    rd(3'd5, 1, 32'h1, 0, "R6 set wins flag");
    rd(3'd0, 1, c0 + 32'd2, 0, "R6 capture value");

    // R7 alternate trigger gated by control bit 8
    @(negedge clk); cmp_match = 1;
    @(negedge clk); cmp_match = 0;
    idle(2);
    rd(3'd3, 1, 32'h0, 0, "R7 compare ignored when disabled");
    wr(3'd4, 32'h139);
    @(negedge clk); cmp_match = 1; c3 = cnt_val;
    @(negedge clk); cmp_match = 0;
    idle(2);
    rd(3'd3, 1, c3, 0, "R7 compare capture value");
    rd(3'd5, 1, 32'h9, 0, "R7 ch3 flag");

    // R8 coincident pin edge and compare pulse
    wr(3'd4, 32'h179);
    pin(3, 1, c3);
    @(negedge clk);
    @(negedge clk); cmp_match = 1;
    @(negedge clk); cmp_match = 0;
    idle(4);
    rd(3'd3, 1, c3 + 32'd2, 0, "R8 single capture value");

    // R10 standby
    @(negedge clk); standby = 1;
    cap_pin[2] = 1;
    idle(2);
    rd(3'd0, 1, 32'h0, 0, "R10 cleared during standby");
    idle(6);
    @(negedge clk); standby = 0;
    idle(5);
    for (int a = 0; a < 4; a++) rd(3'(a), 1, 32'h0, 0, "R10 capture after standby");
    rd(3'd5, 1, 32'h0, 0, "R10 flags after standby");
    rd(3'd4, 1, 32'h179, 0, "R10 control kept");

    idle(3);
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 100000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule